// File: doc/BRIEF.md
# BCD Time-of-Day Clock Register File

This block keeps calendar time in packed BCD: seconds, minutes, hours (24-hour), day of week, day of month, month and a two-digit year. A fixed-rate pulse on `tick_i` drives a prescaler. The prescaler produces one carry into the seconds counter for every `TICKS_PER_SEC` pulses. From there, carries ripple through the calendar fields. Month length and leap years are honoured.

Software reaches the clock through eight byte-wide registers at the top eight addresses of an `ADDR_W`-bit byte window. A write takes effect on the clock edge. Reads are combinational from the address.

Two bits in the control byte separate what the host sees from the live counters:
- **Freeze bit:** gives a stable snapshot for a multi-byte read while the time keeps running.
- **Load bit:** opens a staging copy. On release, the staging copy is loaded into the counters in a single clock.

Three further flags share bytes with the time fields: an oscillator halt flag, a kick-start flag and a frequency-test flag. A six-bit calibration field in the control byte is storage only.

Top module: `rtc_regfile`

## Requirements
- R1: Registers are decoded only when `addr_i[ADDR_W-1:3]` is all ones. Index `addr_i[2:0]` selects, in order: 0 control, 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 date, 6 month, 7 year. Outside the window, reads return 0x00 and writes change nothing. After reset the registers read 00 00 00 00 01 01 01 00 for indices 0 to 7.
- R2: Time fields are packed BCD, with the tens digit in bits 7:4 and units in bits 3:0. The stored field widths are: seconds 6:0, minutes 6:0, hours 5:0, day of week 2:0, date 5:0, month 4:0, year 7:0. Bits not listed here or in R8/R11 read as 0.
- R3: The seconds count advances by one exactly on the `TICKS_PER_SEC`-th accepted `tick_i` pulse.
- R4: Seconds wrap 59→00 and carry into minutes. Minutes wrap 59→00 and carry into hours. Hours wrap 23→00 and carry into the day.
- R5: On a day carry, day of week steps 1..7 and wraps 07→01.
- R6: On a day carry, the date wraps to 01 after the last day of the month. April, June, September and November have 30 days. February has 29 days when the year value is divisible by 4 and 28 days otherwise. All other months have 31 days.
- R7: Month wraps 12→01 and increments the year. Year wraps 99→00.
- R8: Bit 7 of the seconds register is a halt flag and takes effect on write. While it is set, ticks are ignored and every time field holds its value.
- R9: Bit 7 of the control register is the load bit.
  - When it goes 0→1, the staging copy is filled from the live counters.
  - Time-field writes always go only to the staging copy and are never visible in the live view.
  - When it goes 1→0, all staged fields load into the counters on that clock, and the prescaler is cleared.
- R10: Bit 6 of the control register is the freeze bit.
  - When it goes 0→1, the live counters are copied to a snapshot, and time reads return the snapshot while the bit stays set.
  - The live counters keep running, including carries through the full calendar, and become visible again once the bit is cleared.
- R11: Three further flags are stored on write and read back: kick-start (hours bit 7), frequency test (day-of-week bit 6) and calibration (control bits 5:0). None of them changes counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Time-base pulse, one cycle wide |
| addr_i | input | ADDR_W | Byte address |
| we_i | input | 1 | Write strobe for `wdata_i` at `addr_i` |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |

## Verification
The hardest states to reach from the ports are the last second of the last day of each month, for every year value. Only there do the date, month and year carries and the leap-year rule act.

The bench reaches each of these states directly. It uses the load-bit sequence to place the counters at 23:59:59 on the final day, for all twelve months across all hundred years. It then supplies exactly one second of ticks and checks the date, month and year that follow. The same end-of-century instant is also crossed while the freeze bit is set, to show the carry completes unseen and appears once the bit is released.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [6:0] sec;
    logic [6:0] min;
    logic [5:0] hour;
    logic [2:0] dow;
    logic [5:0] date;
    logic [4:0] mon;
    logic [7:0] year;
  } rtc_time_t;

  typedef enum logic [2:0] {
    REG_CTRL = 3'd0,
    REG_SEC  = 3'd1,
    REG_MIN  = 3'd2,
    REG_HOUR = 3'd3,
    REG_DOW  = 3'd4,
    REG_DATE = 3'd5,
    REG_MON  = 3'd6,
    REG_YEAR = 3'd7
  } rtc_reg_e;

  localparam rtc_time_t TIME_RST = '{sec: 7'h00, min: 7'h00, hour: 6'h00, dow: 3'd1,
                                     date: 6'h01, mon: 5'h01, year: 8'h00};

  // units digit wraps 9 -> 0 with carry into tens
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'h9) return {v[7:4] + 4'h1, 4'h0};
    return v + 8'h01;
  endfunction

  // divisible by 4 in BCD: tens even -> units 0/4/8, tens odd -> units 2/6
  function automatic logic leap_year(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'h2) || (y[3:0] == 4'h6);
    return (y[3:0] == 4'h0) || (y[3:0] == 4'h4) || (y[3:0] == 4'h8);
  endfunction

  function automatic logic [5:0] month_last(input logic [4:0] m, input logic [7:0] y);
    case (m)
      5'h02:                      return leap_year(y) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned TICKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_i,
  input  logic clear_i,
  output logic sec_o
);

  localparam int unsigned CW = (TICKS > 1) ? $clog2(TICKS) : 1;

  generate
    if (TICKS <= 1) begin : g_direct
      assign sec_o = tick_i && run_i && !clear_i;
    end else begin : g_count
      localparam logic [CW-1:0] LAST = CW'(TICKS - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)               cnt_q <= '0;
        else if (clear_i)          cnt_q <= '0;
        else if (tick_i && run_i)  cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
      end

      assign sec_o = tick_i && run_i && !clear_i && (cnt_q == LAST);

      AST_PRESC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= LAST); // R3
      AST_PRESC_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> cnt_q == '0); // R9
    end
  endgenerate

endmodule

// File: rtl/rtc_counters.sv
module rtc_counters
  import rtc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      adv_i,
  input  logic      load_i,
  input  rtc_time_t load_val_i,
  output rtc_time_t time_o
);

  rtc_time_t  cur_q, nxt;
  logic       c_min, c_hour, c_day, c_mon, c_year;
  logic [5:0] last_day;

  always_comb begin
    last_day = month_last(cur_q.mon, cur_q.year);
    c_min    = adv_i  && (cur_q.sec  >= 7'h59);
    c_hour   = c_min  && (cur_q.min  >= 7'h59);
    c_day    = c_hour && (cur_q.hour >= 6'h23);
    c_mon    = c_day  && (cur_q.date >= last_day);
    c_year   = c_mon  && (cur_q.mon  >= 5'h12);

    nxt = cur_q;
    if (adv_i)  nxt.sec  = c_min  ? 7'h00 : 7'(bcd_inc({1'b0, cur_q.sec}));
    if (c_min)  nxt.min  = c_hour ? 7'h00 : 7'(bcd_inc({1'b0, cur_q.min}));
    if (c_hour) nxt.hour = c_day  ? 6'h00 : 6'(bcd_inc({2'b00, cur_q.hour}));
    if (c_day) begin
      nxt.dow  = (cur_q.dow >= 3'd7) ? 3'd1 : cur_q.dow + 3'd1;
      nxt.date = c_mon ? 6'h01 : 6'(bcd_inc({2'b00, cur_q.date}));
    end
    if (c_mon)  nxt.mon  = c_year ? 5'h01 : 5'(bcd_inc({3'b000, cur_q.mon}));
    if (c_year) nxt.year = (cur_q.year >= 8'h99) ? 8'h00 : bcd_inc(cur_q.year);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cur_q <= TIME_RST;
    else if (load_i) cur_q <= load_val_i;
    else             cur_q <= nxt;
  end

  assign time_o = cur_q;

  AST_LOAD_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> time_o == $past(load_val_i)); // R9
  AST_SEC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !load_i && cur_q.sec == 7'h59 |=> cur_q.sec == 7'h00); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i && !load_i |=> $stable(cur_q)); // R8
  AST_YEAR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_year && !load_i && cur_q.year == 8'h99 |=> cur_q.year == 8'h00 && cur_q.mon == 5'h01); // R7

endmodule

// File: rtl/rtc_host_if.sv
module rtc_host_if
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [7:0]        wdata_i,
  input  rtc_time_t         live_i,
  output logic [7:0]        rdata_o,
  output rtc_time_t         stage_o,
  output logic              load_o,
  output logic              stop_o
);

  logic      in_win, wr_hit, ctrl_wr;
  logic      w_rise, w_fall, r_rise;
  rtc_reg_e  idx;
  logic      wr_q, rd_q, stop_q, kick_q, ftest_q;
  logic [5:0] cal_q;
  rtc_time_t stage_q, snap_q, view;

  assign in_win  = &addr_i[ADDR_W-1:3];
  assign idx     = rtc_reg_e'(addr_i[2:0]);
  assign wr_hit  = we_i && in_win;
  assign ctrl_wr = wr_hit && (idx == REG_CTRL);
  assign w_rise  = ctrl_wr &&  wdata_i[7] && !wr_q;
  assign w_fall  = ctrl_wr && !wdata_i[7] &&  wr_q;
  assign r_rise  = ctrl_wr &&  wdata_i[6] && !rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      cal_q   <= '0;
      stop_q  <= 1'b0;
      kick_q  <= 1'b0;
      ftest_q <= 1'b0;
    end else if (wr_hit) begin
      case (idx)
        REG_CTRL: begin
          wr_q  <= wdata_i[7];
          rd_q  <= wdata_i[6];
          cal_q <= wdata_i[5:0];
        end
        REG_SEC:  stop_q  <= wdata_i[7];
        REG_HOUR: kick_q  <= wdata_i[7];
        REG_DOW:  ftest_q <= wdata_i[6];
        default:  ;
      endcase
    end
  end

  // staging: refreshed from live when load bit opens, then patched by writes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= TIME_RST;
    end else if (w_rise) begin
      stage_q <= live_i;
    end else if (wr_hit) begin
      case (idx)
        REG_SEC:  stage_q.sec  <= wdata_i[6:0];
        REG_MIN:  stage_q.min  <= wdata_i[6:0];
        REG_HOUR: stage_q.hour <= wdata_i[5:0];
        REG_DOW:  stage_q.dow  <= wdata_i[2:0];
        REG_DATE: stage_q.date <= wdata_i[5:0];
        REG_MON:  stage_q.mon  <= wdata_i[4:0];
        REG_YEAR: stage_q.year <= wdata_i;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     snap_q <= TIME_RST;
    else if (r_rise) snap_q <= live_i;
  end

  assign view = rd_q ? snap_q : live_i;

  always_comb begin
    rdata_o = 8'h00;
    if (in_win) begin
      case (idx)
        REG_CTRL: rdata_o = {wr_q, rd_q, cal_q};
        REG_SEC:  rdata_o = {stop_q, view.sec};
        REG_MIN:  rdata_o = {1'b0, view.min};
        REG_HOUR: rdata_o = {kick_q, 1'b0, view.hour};
        REG_DOW:  rdata_o = {1'b0, ftest_q, 3'b000, view.dow};
        REG_DATE: rdata_o = {2'b00, view.date};
        REG_MON:  rdata_o = {3'b000, view.mon};
        REG_YEAR: rdata_o = view.year;
        default:  rdata_o = 8'h00;
      endcase
    end
  end

  assign stage_o = stage_q;
  assign load_o  = w_fall;
  assign stop_o  = stop_q;

  AST_SNAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_q |=> $stable(snap_q)); // R10
  AST_STAGE_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_rise |=> stage_q == $past(live_i)); // R9
  AST_WIN_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && !in_win |=> $stable(stage_q) && $stable(cal_q) && $stable(stop_q)); // R1

endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W        = 11,
  parameter int unsigned TICKS_PER_SEC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);

  rtc_time_t live, stage;
  logic      load, stop, sec_pulse;

  rtc_prescaler #(.TICKS(TICKS_PER_SEC)) u_presc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .run_i   (!stop),
    .clear_i (load),
    .sec_o   (sec_pulse)
  );

  rtc_counters u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (sec_pulse),
    .load_i     (load),
    .load_val_i (stage),
    .time_o     (live)
  );

  rtc_host_if #(.ADDR_W(ADDR_W)) u_host (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .we_i    (we_i),
    .wdata_i (wdata_i),
    .live_i  (live),
    .rdata_o (rdata_o),
    .stage_o (stage),
    .load_o  (load),
    .stop_o  (stop)
  );

  AST_STOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop && !load |=> $stable(live)); // R8

endmodule

// File: tb/rtc_regfile_bench.sv
module rtc_regfile_bench;
  localparam int TPS = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick = 1'b0;
  logic        we = 1'b0;
  logic [10:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  rtc_regfile #(.ADDR_W(11), .TICKS_PER_SEC(TPS)) u_rtc_regfile (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .addr_i(addr),
    .we_i(we), .wdata_i(wdata), .rdata_o(rdata)
  );

  function automatic logic [7:0] bcd(int n);
    return 8'(((n / 10) << 4) | (n % 10));
  endfunction

  function automatic int dim(int m, int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic chk(string req, string what, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got=%02h exp=%02h", req, what, got, exp);
    end
  endtask

  task automatic wr_raw(logic [10:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic wr(int i, logic [7:0] d);
    wr_raw(11'h7F8 + 11'(i), d);
  endtask

  task automatic rd_raw_chk(string req, logic [10:0] a, logic [7:0] exp);
    addr = a; #1;
    chk(req, $sformatf("addr %03h", a), rdata, exp);
  endtask

  task automatic rd_chk(string req, int i, logic [7:0] exp);
    rd_raw_chk(req, 11'h7F8 + 11'(i), exp);
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic set_time(int s, int mi, int h, int dw, int dt, int mo, int y);
    wr(0, 8'h80);
    wr(1, bcd(s)); wr(2, bcd(mi)); wr(3, bcd(h)); wr(4, 8'(dw));
    wr(5, bcd(dt)); wr(6, bcd(mo)); wr(7, bcd(y));
    wr(0, 8'h00);
  endtask

  task automatic chk_time(string req, int s, int mi, int h, int dw, int dt, int mo, int y);
    rd_chk(req, 1, bcd(s)); rd_chk(req, 2, bcd(mi)); rd_chk(req, 3, bcd(h));
    rd_chk(req, 4, 8'(dw)); rd_chk(req, 5, bcd(dt)); rd_chk(req, 6, bcd(mo));
    rd_chk(req, 7, bcd(y));
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state and window decode
    rd_chk("R1", 0, 8'h00);
    chk_time("R1", 0, 0, 0, 1, 1, 1, 0);
    rd_raw_chk("R1", 11'h000, 8'h00);
    rd_raw_chk("R1", 11'h3F9, 8'h00);
    wr_raw(11'h3F9, 8'h80);
    wr_raw(11'h7F0, 8'h7F);
    rd_chk("R1", 0, 8'h00);
    ticks(TPS);
    rd_chk("R1", 1, 8'h01);

    // R3 one second per TPS ticks
    set_time(0, 0, 0, 1, 1, 1, 0);
    ticks(TPS - 1);
    rd_chk("R3", 1, 8'h00);
    ticks(1);
    rd_chk("R3", 1, 8'h01);

    // R9 prescaler cleared by load
    ticks(2);
    set_time(10, 0, 0, 1, 1, 1, 0);
    ticks(TPS - 1);
    rd_chk("R9", 1, bcd(10));
    ticks(1);
    rd_chk("R9", 1, bcd(11));

    // R4 sweep one full minute
    set_time(0, 0, 0, 1, 1, 1, 0);
    for (int s = 1; s <= 60; s++) begin
      ticks(TPS);
      rd_chk("R4", 1, bcd(s % 60));
      rd_chk("R4", 2, bcd(s / 60));
    end
    set_time(59, 59, 9, 1, 1, 1, 0);
    ticks(TPS);
    chk_time("R4", 0, 0, 10, 1, 1, 1, 0);
    set_time(59, 59, 23, 3, 15, 6, 20);
    ticks(TPS);
    chk_time("R4", 0, 0, 0, 4, 16, 6, 20);

    // R5 day of week wrap
    set_time(59, 59, 23, 7, 10, 3, 5);
    ticks(TPS);
    rd_chk("R5", 4, 8'h01);

    // R6 R7 every month end of every year
    for (int y = 0; y < 100; y++) begin
      for (int m = 1; m <= 12; m++) begin
        set_time(59, 59, 23, 2, dim(m, y), m, y);
        ticks(TPS);
        rd_chk("R6", 5, 8'h01);
        rd_chk("R7", 6, bcd(m % 12 + 1));
        rd_chk("R7", 7, bcd(m == 12 ? (y + 1) % 100 : y));
      end
      set_time(59, 59, 23, 2, 28, 2, y);
      ticks(TPS);
      rd_chk("R6", 5, bcd((y % 4 == 0) ? 29 : 1));
    end

    // R2 field widths and zero bits
    set_time(0, 0, 0, 1, 1, 1, 0);
    wr(0, 8'h80);
    wr(2, 8'hFF); wr(3, 8'h7F); wr(4, 8'hBF); wr(5, 8'hFF); wr(6, 8'hFF);
    wr(0, 8'h00);
    rd_chk("R2", 2, 8'h7F);
    rd_chk("R2", 3, 8'h3F);
    rd_chk("R2", 4, 8'h07);
    rd_chk("R2", 5, 8'h3F);
    rd_chk("R2", 6, 8'h1F);

    // R8 halt flag
    set_time(56, 34, 12, 1, 1, 1, 0);
    wr(1, 8'h80);
    rd_chk("R8", 1, 8'hD6);
    ticks(3 * TPS);
    rd_chk("R8", 1, 8'hD6);
    rd_chk("R8", 2, 8'h34);
    wr(1, 8'h00);
    ticks(TPS);
    rd_chk("R8", 1, 8'h57);

    // R9 staging isolation and fill on open
    set_time(0, 0, 5, 1, 1, 1, 0);
    wr(0, 8'h80);
    wr(2, bcd(30));
    rd_chk("R9", 2, 8'h00);
    wr(0, 8'h00);
    rd_chk("R9", 2, bcd(30));
    rd_chk("R9", 3, bcd(5));
    wr(2, bcd(45));
    rd_chk("R9", 2, bcd(30));
    wr(0, 8'h80);
    wr(0, 8'h00);
    rd_chk("R9", 2, bcd(30));

    // R10 freeze across century rollover
    set_time(59, 59, 23, 5, 31, 12, 99);
    wr(0, 8'h40);
    ticks(TPS);
    rd_chk("R10", 0, 8'h40);
    chk_time("R10", 59, 59, 23, 5, 31, 12, 99);
    wr(0, 8'h00);
    chk_time("R10", 0, 0, 0, 6, 1, 1, 0);

    // R11 side flags
    set_time(0, 0, 0, 1, 1, 1, 0);
    wr(3, 8'h80);
    wr(4, 8'h41);
    wr(0, 8'h3F);
    ticks(TPS);
    rd_chk("R11", 1, 8'h01);
    rd_chk("R11", 3, 8'h80);
    rd_chk("R11", 4, 8'h41);
    rd_chk("R11", 0, 8'h3F);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule